// File: doc/BRIEF.md
# Transmit Channel Priority Scheduler

This block decides which of several transmit DMA channels is served next. Each channel raises a request by holding the pending level of its source queue high. Each channel also has a two-bit priority that software can set. The scheduler gives the output to one channel at a time. That channel then moves one packet, as a series of 128-bit beats, onto a streaming output. Fetching descriptors and moving packet data happen outside the block. They are modelled as a handshake: the scheduler issues a grant and holds it until it sees a completion pulse.

Arbitration has two stages. First it picks the most urgent priority level that has a live request. Level 0 is the most urgent and level 3 the least. Within that level, each level keeps its own round-robin pointer and picks the next requesting channel at or after that pointer. A level's pointer moves only when a grant at that level completes. The stream path does not look at the payload. It forwards beats tagged with the granted channel and drops any beat that arrives while no grant is active.

The controller has two states. ST_IDLE waits for any eligible request; the ARBITRATE transition latches the winning channel and its level and moves to ST_BUSY. ST_BUSY holds the grant; the RELEASE transition happens on the completion pulse, advances the pointer of the granted level and returns to ST_IDLE.

Top module: `txs_top`

## Requirements
- R1: After reset, no grant is active (`grant_valid_o`=0), every channel's priority is 3, and every level's round-robin pointer is channel 0.
- R2: In ST_IDLE, if any channel has its pending bit set, the clock edge that sees it sets `grant_valid_o`. `grant_ch_o` then shows the winning channel index in binary.
- R3: At an arbitration point, a requesting channel at a numerically lower priority always wins over every channel at a higher value (0 is the most urgent).
- R4: Within one level, the winner is the first requesting channel found by searching upward from the level's pointer and wrapping past channel 7. When a grant completes, that level's pointer becomes the granted channel plus one, modulo 8.
- R5: A grant is held with an unchanged channel until `done_i` is high at a clock edge. While it is held, changes on the pending inputs do not affect the grant.
- R6: The edge that sees `done_i` clears `grant_valid_o` for at least one cycle. The next arbitration happens at the following edge.
- R7: A priority write (`prio_wr_i`, `prio_wr_ch_i`, `prio_wr_val_i`) takes effect at the clock edge. It is ignored if the target channel holds the active grant at that edge.
- R8: A channel whose pending bit drops before it is granted is not granted.
- R9: When no pending bit is set, no grant is issued and the round-robin pointers keep their values.
- R10: `strm_valid_o` follows `beat_valid_i` only while a grant is active, with `strm_ch_o` equal to the granted channel and `strm_data_o` equal to `beat_data_i`. At all other times `strm_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 8 | Queue-pending request level, one bit per channel |
| prio_wr_i | input | 1 | Priority write strobe |
| prio_wr_ch_i | input | 3 | Channel whose priority is written |
| prio_wr_val_i | input | 2 | New priority value (0 = most urgent) |
| done_i | input | 1 | Packet-complete pulse for the active grant |
| beat_valid_i | input | 1 | Data beat valid from the packet mover |
| beat_data_i | input | 128 | Data beat from the packet mover |
| grant_valid_o | output | 1 | A grant is active |
| grant_ch_o | output | 3 | Index of the granted channel |
| strm_valid_o | output | 1 | Streaming output beat valid |
| strm_data_o | output | 128 | Streaming output data |
| strm_ch_o | output | 3 | Channel tag of the streaming beat |

## Verification
The bench builds the block with its default parameters: 8 channels, 4 priority levels and a 128-bit data path. With 8 channels, four levels can hold live requests at the same time, and a round-robin pointer can be driven past channel 7 so that the wrap-around is observed. A channel's priority can also be moved between levels partway through a run. This lets the directed sequences reach strict priority between levels, ordering and pointer wrap within a level, rejected writes to the granted channel, and requests that are withdrawn before they are granted.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } sched_state_t;
endpackage

// File: rtl/txs_prio_regs.sv
// Per-channel priority storage; a write aimed at the channel that holds
// the active grant is discarded.
module txs_prio_regs #(
    parameter int NUM_CH   = 8,
    parameter int PW       = 2,
    parameter int RST_PRIO = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_CH)-1:0]     wr_ch,
    input  logic [PW-1:0]                 wr_val,
    input  logic                          busy_valid,
    input  logic [$clog2(NUM_CH)-1:0]     busy_ch,
    output logic [NUM_CH-1:0][PW-1:0]     prio_o
);
    localparam int CHW = $clog2(NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CHW'(c)) &&
                     !(busy_valid && (busy_ch == CHW'(c)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_o[c] <= PW'(RST_PRIO);
            else if (hit)
                prio_o[c] <= wr_val;
        end
    end
endmodule

// File: rtl/txs_level_rr.sv
// Round-robin picker for one priority level with its own pointer.
module txs_level_rr #(
    parameter int NUM_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         req,
    input  logic                      adv,
    input  logic [$clog2(NUM_CH)-1:0] adv_ch,
    output logic                      hit,
    output logic [$clog2(NUM_CH)-1:0] pick
);
    localparam int CHW = $clog2(NUM_CH);

    logic [CHW-1:0] ptr;
    logic [CHW-1:0] idx;

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        idx  = '0;
        for (int off = 0; off < NUM_CH; off++) begin
            idx = ptr + CHW'(off);
            if (!hit && req[idx]) begin
                hit  = 1'b1;
                pick = idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= adv_ch + CHW'(1);
    end
endmodule

// File: rtl/txs_top.sv
// Transmit channel scheduler: strict priority between levels,
// round robin inside a level, grant held until packet completion.
module txs_top #(
    parameter int NUM_CH   = 8,
    parameter int NUM_LVL  = 4,
    parameter int DATA_W   = 128,
    parameter int RST_PRIO = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         pend_i,
    input  logic                      prio_wr_i,
    input  logic [$clog2(NUM_CH)-1:0] prio_wr_ch_i,
    input  logic [$clog2(NUM_LVL)-1:0] prio_wr_val_i,
    input  logic                      done_i,
    input  logic                      beat_valid_i,
    input  logic [DATA_W-1:0]         beat_data_i,
    output logic                      grant_valid_o,
    output logic [$clog2(NUM_CH)-1:0] grant_ch_o,
    output logic                      strm_valid_o,
    output logic [DATA_W-1:0]         strm_data_o,
    output logic [$clog2(NUM_CH)-1:0] strm_ch_o
);
    import txs_pkg::*;

    localparam int CHW = $clog2(NUM_CH);
    localparam int PW  = $clog2(NUM_LVL);

    sched_state_t                state_q, state_d;
    logic [CHW-1:0]              gch_q;
    logic [PW-1:0]               glvl_q;
    logic [NUM_CH-1:0][PW-1:0]   prio;
    logic [NUM_LVL-1:0]          lvl_hit;
    logic [NUM_LVL-1:0][CHW-1:0] lvl_pick;
    logic                        any_hit;
    logic [PW-1:0]               win_lvl;
    logic [CHW-1:0]              win_ch;
    logic                        busy;

    assign busy = (state_q == ST_BUSY);

    txs_prio_regs #(
        .NUM_CH   (NUM_CH),
        .PW       (PW),
        .RST_PRIO (RST_PRIO)
    ) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prio_wr_i),
        .wr_ch      (prio_wr_ch_i),
        .wr_val     (prio_wr_val_i),
        .busy_valid (busy),
        .busy_ch    (gch_q),
        .prio_o     (prio)
    );

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic [NUM_CH-1:0] mask;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_m
            assign mask[c] = pend_i[c] && (prio[c] == PW'(l));
        end
        txs_level_rr #(.NUM_CH(NUM_CH)) u_rr (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (mask),
            .adv    (busy && done_i && (glvl_q == PW'(l))),
            .adv_ch (gch_q),
            .hit    (lvl_hit[l]),
            .pick   (lvl_pick[l])
        );
    end

    // Most urgent (lowest-numbered) level with a request wins.
    always_comb begin
        any_hit = 1'b0;
        win_lvl = '0;
        win_ch  = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (!any_hit && lvl_hit[l]) begin
                any_hit = 1'b1;
                win_lvl = PW'(l);
                win_ch  = lvl_pick[l];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_hit) state_d = ST_BUSY;   // ARBITRATE
            ST_BUSY: if (done_i)  state_d = ST_IDLE;   // RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gch_q   <= '0;
            glvl_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_hit) begin
                gch_q  <= win_ch;
                glvl_q <= win_lvl;
            end
        end
    end

    always_comb begin
        grant_valid_o = busy;
        grant_ch_o    = gch_q;
        strm_valid_o  = busy && beat_valid_i;
        strm_data_o   = beat_data_i;
        strm_ch_o     = gch_q;
    end
endmodule

// File: rtl/txs_checker.sv
module txs_checker #(
    parameter int NUM_CH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         pend_i,
    input logic                      done_i,
    input logic                      grant_valid_o,
    input logic [$clog2(NUM_CH)-1:0] grant_ch_o,
    input logic                      strm_valid_o
);
    // R5: grant and channel held until completion
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && !done_i) |=> (grant_valid_o && $stable(grant_ch_o)));

    // R6: completion releases the grant
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && done_i) |=> !grant_valid_o);

    // R2: a new grant always targets a channel that was pending
    p_grant_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid_o) |-> ((($past(pend_i) >> grant_ch_o) & NUM_CH'(1)) != '0));

    // R9: no request keeps the grant idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid_o && pend_i == '0) |=> !grant_valid_o);

    // R10: stream beats only under a grant
    p_stream_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        strm_valid_o |-> grant_valid_o);
endmodule

bind txs_top txs_checker #(.NUM_CH(NUM_CH)) u_txs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pend_i        (pend_i),
    .done_i        (done_i),
    .grant_valid_o (grant_valid_o),
    .grant_ch_o    (grant_ch_o),
    .strm_valid_o  (strm_valid_o)
);

// File: tb/test_txs_top.sv
module test_txs_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   pend_i = '0;
    logic         prio_wr_i = 1'b0;
    logic [2:0]   prio_wr_ch_i = '0;
    logic [1:0]   prio_wr_val_i = '0;
    logic         done_i = 1'b0;
    logic         beat_valid_i = 1'b0;
    logic [127:0] beat_data_i = '0;
    logic         grant_valid_o;
    logic [2:0]   grant_ch_o;
    logic         strm_valid_o;
    logic [127:0] strm_data_o;
    logic [2:0]   strm_ch_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    txs_top i_txs_top (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i),
        .prio_wr_i(prio_wr_i), .prio_wr_ch_i(prio_wr_ch_i), .prio_wr_val_i(prio_wr_val_i),
        .done_i(done_i), .beat_valid_i(beat_valid_i), .beat_data_i(beat_data_i),
        .grant_valid_o(grant_valid_o), .grant_ch_o(grant_ch_o),
        .strm_valid_o(strm_valid_o), .strm_data_o(strm_data_o), .strm_ch_o(strm_ch_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_grant(string req, int ch);
        check(req, {127'd0, grant_valid_o}, 128'd1);
        check(req, {125'd0, grant_ch_o}, 128'(ch));
    endtask

    task automatic finish_grant(logic [7:0] pend_after);
        done_i = 1'b1;
        pend_i = pend_after;
        tick();
        done_i = 1'b0;
        check("R6", {127'd0, grant_valid_o}, 128'd0);
    endtask

    task automatic write_prio(int ch, int val);
        prio_wr_i = 1'b1;
        prio_wr_ch_i = 3'(ch);
        prio_wr_val_i = 2'(val);
        tick();
        prio_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", {127'd0, grant_valid_o}, 128'd0);
        check("R1", {127'd0, strm_valid_o}, 128'd0);
    endtask

    // all at priority 3; pointer starts at 0
    task automatic t_round_robin();
        pend_i = 8'b0010_0101;
        tick(); expect_grant("R4", 0);
        finish_grant(8'b0010_0101);
        tick(); expect_grant("R4", 2);
        finish_grant(8'b0010_0101);
        tick(); expect_grant("R4", 5);
        finish_grant(8'b0010_0101);
        tick(); expect_grant("R4", 0);    // wrap past 7
        finish_grant(8'h00);
    endtask

    task automatic t_priority();
        write_prio(6, 0);
        write_prio(1, 1);
        pend_i = 8'b0100_1010;
        tick(); expect_grant("R3", 6);
        finish_grant(8'b0100_1010);
        tick(); expect_grant("R3", 6);
        finish_grant(8'b0000_1010);
        tick(); expect_grant("R3", 1);
        finish_grant(8'b0000_1000);
        tick(); expect_grant("R3", 3);
        finish_grant(8'h00);
    endtask

    task automatic t_hold();
        pend_i = 8'b0000_1000;
        tick(); expect_grant("R2", 3);
        pend_i = 8'b0100_0000;            // urgent ch6 arrives, ch3 drops
        repeat (3) begin
            tick(); expect_grant("R5", 3);
        end
        finish_grant(8'b0100_0000);
        tick(); expect_grant("R5", 6);
        finish_grant(8'h00);
    endtask

    task automatic t_write_locked();
        pend_i = 8'b0000_0100;
        tick(); expect_grant("R7", 2);
        write_prio(2, 0);                  // ignored: ch2 granted
        write_prio(5, 2);                  // accepted
        finish_grant(8'b0010_0100);
        tick(); expect_grant("R7", 5);
        finish_grant(8'h00);
    endtask

    task automatic t_skip();
        pend_i = 8'b0000_0001;
        tick(); expect_grant("R8", 0);
        pend_i = 8'b1001_0001;
        tick();
        pend_i = 8'b1000_0001;             // ch4 withdrawn before grant
        tick();
        finish_grant(8'b1000_0000);
        tick(); expect_grant("R8", 7);
        finish_grant(8'h00);
    endtask

    task automatic t_idle();
        repeat (4) begin
            tick(); check("R9", {127'd0, grant_valid_o}, 128'd0);
        end
        pend_i = 8'b0001_0001;             // level-3 pointer still at 0
        tick(); expect_grant("R9", 0);
        finish_grant(8'h00);
    endtask

    task automatic t_stream();
        beat_valid_i = 1'b1;
        beat_data_i = {4{32'hA5C3_0F96}};
        tick();
        check("R10", {127'd0, strm_valid_o}, 128'd0);
        pend_i = 8'b0001_0000;
        tick(); expect_grant("R10", 4);
        check("R10", {127'd0, strm_valid_o}, 128'd1);
        check("R10", strm_data_o, {4{32'hA5C3_0F96}});
        check("R10", {125'd0, strm_ch_o}, 128'd4);
        beat_valid_i = 1'b0;
        #1;
        check("R10", {127'd0, strm_valid_o}, 128'd0);
        finish_grant(8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_round_robin();
        t_priority();
        t_hold();
        t_write_locked();
        t_skip();
        t_idle();
        t_stream();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule